// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This unit performs the four partial-word merge operations a processor pipeline needs to load or store a 32-bit word at any byte alignment in a little-endian memory. The two load forms (left and right) combine the bytes of an aligned memory word with the current value of the destination register. The two store forms combine bytes of the source register into the aligned memory word and write the result back. A full unaligned word access is normally issued as one left form and one right form at the two ends of the word.

The caller presents an opcode, a byte address, a register index and the present register value for one cycle. The unit reads the aligned word through a read port with one cycle of latency, merges in the next cycle, and then presents a registered result. A load result goes out as a register write strobe. A store result goes out as a memory write strobe at the aligned address. The register file, the memory, the address adder and exception handling belong to the surrounding pipeline.

Top module: `umerge_unit`

## Requirements
- R1: Every memory read and write uses the aligned word address, which is the byte address with its two low bits cleared. The byte offset k is those two bits.
- R2: Load-left (opcode 34): result bytes 3-k..3 are memory bytes 0..k in the same order. The other result bytes keep the register value. Byte 0 is bits 7:0.
- R3: Load-right (opcode 38): result bytes 0..3-k are memory bytes k..3. The other result bytes keep the register value.
- R4: Store-left (opcode 42): written word bytes 0..k are register bytes 3-k..3. The other bytes keep the memory word.
- R5: Store-right (opcode 46): written word bytes k..3 are register bytes 0..3-k. The other bytes keep the memory word.
- R6: A load with register index 0 pulses res_valid but never raises reg_wr_en. A store whose register index is 0 still writes memory.
- R7: An accepted request raises mem_rd_en in its own cycle. busy is high for exactly the next cycle. res_valid and the write strobe pulse for one cycle in the cycle after busy.
- R8: A request is ignored while busy is high. A request with any opcode other than 34, 38, 42 or 46 is ignored. An ignored request produces no read, no strobe and no result.
- R9: After reset, busy, mem_rd_en, mem_wr_en, reg_wr_en and res_valid are all low.
- R10: reg_wr_en and mem_wr_en are never high together, and either one is high only while res_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Primary opcode field |
| req_addr | input | 32 | Byte address of the access |
| req_idx | input | 5 | Register index (destination for loads, source for stores) |
| req_reg | input | 32 | Current value of the indexed register |
| busy | output | 1 | Merge cycle in progress; requests are not taken |
| mem_rd_en | output | 1 | Read strobe for the aligned word |
| mem_rd_addr | output | 32 | Aligned read address |
| mem_rd_data | input | 32 | Read data, one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Store write strobe |
| mem_wr_addr | output | 32 | Aligned write address |
| mem_wr_data | output | 32 | Merged store word |
| reg_wr_en | output | 1 | Load write strobe |
| reg_wr_idx | output | 5 | Load destination index |
| reg_wr_data | output | 32 | Merged load word |
| res_valid | output | 1 | Result presented this cycle |

## Verification
On every cycle the assertions check the handshake. A read leads to busy, and busy leads to a single-cycle result. No read is issued while busy. The two write strobes are exclusive and appear only with res_valid. Write addresses are aligned, and index 0 is never written. The byte contents of the four merges at all four offsets can only be checked by the bench scenarios against an independent byte-lane model. The same holds for the rule that index 0 suppresses writes for loads but not for stores, and for requests dropped while busy or with an unknown opcode.

// File: rtl/umerge_pkg.sv
package umerge_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_LD_LEFT  = 6'd34;
    localparam logic [OPC_W-1:0] OPC_LD_RIGHT = 6'd38;
    localparam logic [OPC_W-1:0] OPC_ST_LEFT  = 6'd42;
    localparam logic [OPC_W-1:0] OPC_ST_RIGHT = 6'd46;

    // bit 3 of the 6-bit field separates loads from stores,
    // bit 2 separates the left form from the right form
    localparam int STORE_BIT = 3;
    localparam int RIGHT_BIT = 2;

    typedef enum logic [1:0] {
        MK_LD_LEFT  = 2'b00,
        MK_LD_RIGHT = 2'b01,
        MK_ST_LEFT  = 2'b10,
        MK_ST_RIGHT = 2'b11
    } merge_kind_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_MERGE = 1'b1
    } phase_e;

    function automatic logic kind_is_store(merge_kind_e k);
        return k[1];
    endfunction

endpackage

// File: rtl/umerge_decode.sv
module umerge_decode
    import umerge_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    output logic             legal,
    output merge_kind_e      kind
);

    logic is_store;
    logic is_right;

    always_comb begin
        legal = (op == OPC_LD_LEFT)  || (op == OPC_LD_RIGHT) ||
                (op == OPC_ST_LEFT)  || (op == OPC_ST_RIGHT);
        is_store = op[STORE_BIT];
        is_right = op[RIGHT_BIT];
        kind = merge_kind_e'({is_store, is_right});
    end

endmodule

// File: rtl/umerge_align.sv
module umerge_align #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(DATA_W / 8)
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [ADDR_W-1:0] word_addr,
    output logic [OFF_W-1:0]  offset
);

    always_comb begin
        offset    = byte_addr[OFF_W-1:0];
        word_addr = {byte_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

endmodule

// File: rtl/umerge_shift.sv
module umerge_shift
    import umerge_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(DATA_W / 8),
    localparam int SHW   = $clog2(DATA_W) + 1
) (
    input  merge_kind_e       kind,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] mem_val,
    output logic [DATA_W-1:0] merged
);

    localparam logic [SHW-1:0] TOP_SH = SHW'(DATA_W - 8);
    localparam logic [SHW-1:0] BYTE_SH = SHW'(8);
    localparam logic [SHW-1:0] FULL_SH = SHW'(DATA_W);
    localparam logic [DATA_W-1:0] ONES = '1;

    logic [SHW-1:0]    sh;
    logic [SHW-1:0]    sh_inv;
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] high_mask;
    logic [DATA_W-1:0] ldl_w, ldr_w, stl_w, str_w;

    always_comb begin
        sh     = SHW'({offset, 3'b000});
        sh_inv = TOP_SH - sh;
        // shifts of the full width or more give zero, so the masks
        // collapse to all-zero at the extreme offsets
        low_mask  = ONES >> (sh + BYTE_SH);
        high_mask = (ONES << BYTE_SH) << sh_inv;

        ldl_w = (reg_val & low_mask)  | (mem_val << sh_inv);
        ldr_w = (reg_val & high_mask) | (mem_val >> sh);
        stl_w = (reg_val >> sh_inv) | (mem_val & ((ONES << BYTE_SH) << sh));
        str_w = (reg_val << sh)     | (mem_val & (ONES >> (FULL_SH - sh)));

        unique case (kind)
            MK_LD_LEFT:  merged = ldl_w;
            MK_LD_RIGHT: merged = ldr_w;
            MK_ST_LEFT:  merged = stl_w;
            default:     merged = str_w;
        endcase
    end

endmodule

// File: rtl/umerge_unit.sv
module umerge_unit
    import umerge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [5:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_reg,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              reg_wr_en,
    output logic [IDX_W-1:0]  reg_wr_idx,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              res_valid
);

    localparam int OFF_W = $clog2(DATA_W / 8);

    typedef struct packed {
        phase_e            phase;
        merge_kind_e       kind;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] regv;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] waddr;
        logic              res_valid;
        logic              reg_we;
        logic [IDX_W-1:0]  reg_wi;
        logic [DATA_W-1:0] reg_wd;
        logic              mem_we;
        logic [ADDR_W-1:0] mem_wa;
        logic [DATA_W-1:0] mem_wd;
    } state_t;

    state_t d, q;

    logic              dec_legal;
    merge_kind_e       dec_kind;
    logic [ADDR_W-1:0] req_word;
    logic [OFF_W-1:0]  req_off;
    logic [DATA_W-1:0] merged;
    logic              accept;

    umerge_decode u_decode (
        .op    (req_op),
        .legal (dec_legal),
        .kind  (dec_kind)
    );

    umerge_align #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_align (
        .byte_addr (req_addr),
        .word_addr (req_word),
        .offset    (req_off)
    );

    umerge_shift #(.DATA_W(DATA_W)) u_shift (
        .kind    (q.kind),
        .offset  (q.off),
        .reg_val (q.regv),
        .mem_val (mem_rd_data),
        .merged  (merged)
    );

    assign accept      = req_valid && dec_legal && (q.phase == PH_IDLE);
    assign mem_rd_en   = accept;
    assign mem_rd_addr = req_word;
    assign busy        = (q.phase == PH_MERGE);

    always_comb begin
        d = q;
        d.res_valid = 1'b0;
        d.reg_we    = 1'b0;
        d.mem_we    = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (accept) begin
                    d.phase = PH_MERGE;
                    d.kind  = dec_kind;
                    d.off   = req_off;
                    d.regv  = req_reg;
                    d.idx   = req_idx;
                    d.waddr = req_word;
                end
            end
            default: begin
                d.phase     = PH_IDLE;
                d.res_valid = 1'b1;
                if (kind_is_store(q.kind)) begin
                    d.mem_we = 1'b1;
                    d.mem_wa = q.waddr;
                    d.mem_wd = merged;
                end else begin
                    d.reg_we = (q.idx != '0);
                    d.reg_wi = q.idx;
                    d.reg_wd = merged;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_valid   = q.res_valid;
    assign reg_wr_en   = q.reg_we;
    assign reg_wr_idx  = q.reg_wi;
    assign reg_wr_data = q.reg_wd;
    assign mem_wr_en   = q.mem_we;
    assign mem_wr_addr = q.mem_wa;
    assign mem_wr_data = q.mem_wd;

    // R7
    read_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> busy);

    // R7
    busy_then_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (res_valid && !busy));

    // R7
    result_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R8
    no_read_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_rd_en);

    // R10
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && mem_wr_en));

    // R10
    strobe_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || mem_wr_en) |-> res_valid);

    // R1
    write_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_addr[OFF_W-1:0] == '0));

    // R6
    no_zero_index_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_wr_idx != '0));

endmodule

// File: tb/test_umerge_unit.sv
module test_umerge_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 16;

    localparam logic [31:0] MEM_PAT = 32'h44332211;
    localparam logic [31:0] REG_PAT = 32'hDDCCBBAA;

    // stimulus: opcode, byte offset; expected merged word for
    // register REG_PAT and memory word MEM_PAT
    localparam logic [5:0] V_OP [NVEC] = '{
        6'd34, 6'd34, 6'd34, 6'd34,
        6'd38, 6'd38, 6'd38, 6'd38,
        6'd42, 6'd42, 6'd42, 6'd42,
        6'd46, 6'd46, 6'd46, 6'd46 };
    localparam logic [1:0] V_OFF [NVEC] = '{
        2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3,
        2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3 };
    localparam logic [31:0] V_EXP [NVEC] = '{
        32'h11CCBBAA, 32'h2211BBAA, 32'h332211AA, 32'h44332211,
        32'h44332211, 32'hDD443322, 32'hDDCC4433, 32'hDDCCBB44,
        32'h443322DD, 32'h4433DDCC, 32'h44DDCCBB, 32'hDDCCBBAA,
        32'hDDCCBBAA, 32'hCCBBAA11, 32'hBBAA2211, 32'hAA332211 };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_idx = '0;
    logic [31:0] req_reg = '0;
    logic        busy, mem_rd_en, mem_wr_en, reg_wr_en, res_valid;
    logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data, reg_wr_data;
    logic [4:0]  reg_wr_idx;

    int tests = 0;
    int fails = 0;

    logic [31:0] mem [32];

    logic        c_rd_en, c_busy, c_valid, c_reg_we, c_mem_we, c_after;
    logic [31:0] c_rd_addr, c_reg_wd, c_mem_wa, c_mem_wd;

    always #(CLK_PERIOD/2) clk = ~clk;

    umerge_unit i_umerge_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_idx     (req_idx),
        .req_reg     (req_reg),
        .busy        (busy),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_idx  (reg_wr_idx),
        .reg_wr_data (reg_wr_data),
        .res_valid   (res_valid)
    );

    // write-first memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_wr_addr[6:2]] = mem_wr_data;
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[6:2]];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [5:0] op, input logic [31:0] addr,
                          input logic [31:0] rv, input logic [4:0] idx);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_reg = rv; req_idx = idx;
        #1;
        c_rd_en = mem_rd_en; c_rd_addr = mem_rd_addr;
        @(negedge clk);
        req_valid = 1'b0;
        c_busy = busy;
        @(negedge clk);
        c_valid = res_valid; c_reg_we = reg_wr_en; c_reg_wd = reg_wr_data;
        c_mem_we = mem_wr_en; c_mem_wa = mem_wr_addr; c_mem_wd = mem_wr_data;
        @(negedge clk);
        c_after = res_valid;
    endtask

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            6'd34:   return "R2";
            6'd38:   return "R3";
            6'd42:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int w = 0; w < 32; w++) mem[w] = MEM_PAT;
        repeat (3) @(negedge clk);
        // R9: outputs quiet in reset
        check("R9", {27'd0, busy, mem_rd_en, mem_wr_en, reg_wr_en, res_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {27'd0, busy, mem_rd_en, mem_wr_en, reg_wr_en, res_valid}, 32'd0);

        // table walk: word i at 0x100 + 4*i, all words start at MEM_PAT
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] a;
            logic        st;
            a  = 32'h100 + 32'(i * 4) + 32'(V_OFF[i]);
            st = V_OP[i][3];
            run_op(V_OP[i], a, REG_PAT, 5'd7);
            check("R1", {31'd0, c_rd_en}, 32'd1);
            check("R1", c_rd_addr, {a[31:2], 2'b00});
            check("R7", {30'd0, c_busy, c_valid}, 32'd3);
            check("R7", {31'd0, c_after}, 32'd0);
            if (st) begin
                check("R10", {30'd0, c_mem_we, c_reg_we}, 32'd2);
                check("R1", c_mem_wa, {a[31:2], 2'b00});
                check(tag_of(V_OP[i]), c_mem_wd, V_EXP[i]);
                check(tag_of(V_OP[i]), mem[a[6:2]], V_EXP[i]);
            end else begin
                check("R10", {30'd0, c_mem_we, c_reg_we}, 32'd1);
                check(tag_of(V_OP[i]), c_reg_wd, V_EXP[i]);
            end
        end

        // R6: load to index 0 reports a result but writes nothing
        run_op(6'd34, 32'h142, REG_PAT, 5'd0);
        check("R6", {30'd0, c_valid, c_reg_we}, 32'd2);

        // R6: store from index 0 still writes memory
        run_op(6'd46, 32'h144, 32'h0, 5'd0);
        check("R6", {31'd0, c_mem_we}, 32'd1);
        check("R6", mem[5'h11], 32'h0);

        // store then load of the same word
        mem[5'h12] = MEM_PAT;
        run_op(6'd42, 32'h149, REG_PAT, 5'd3);
        run_op(6'd38, 32'h148, 32'hFFFFFFFF, 5'd4);
        check("R3", c_reg_wd, 32'h4433DDCC);

        // R8: request held during busy is not taken
        mem[5'h13] = MEM_PAT;
        @(negedge clk);
        req_valid = 1'b1; req_op = 6'd46; req_addr = 32'h14C; req_reg = REG_PAT; req_idx = 5'd2;
        @(negedge clk);
        req_op = 6'd42; req_addr = 32'h150;
        #1;
        check("R8", {30'd0, busy, mem_rd_en}, 32'd2);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8", {31'd0, res_valid}, 32'd1);
        begin
            int extra = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (res_valid || mem_wr_en) extra++;
            end
            check("R8", 32'(extra), 32'd0);
        end
        check("R8", mem[5'h14], MEM_PAT);

        // R8: unknown opcode is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 6'd35; req_addr = 32'h154; req_reg = REG_PAT; req_idx = 5'd1;
        #1;
        check("R8", {31'd0, mem_rd_en}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R8", {29'd0, res_valid, reg_wr_en, mem_wr_en}, 32'd0);
        check("R8", mem[5'h15], MEM_PAT);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule